// File: doc/BRIEF.md
# Posted Refresh Pacer

This block decides when a DRAM controller must spend time on refresh. A free-running interval timer adds one owed refresh every refresh period. The controller may run traffic and let the debt grow. The pacer starts a refresh sequence in two cases: when the controller reports that it has nothing to do and the debt is above zero, or when the debt reaches its ceiling. Once the ceiling is reached the refresh goes ahead whatever traffic is waiting. The ceiling defaults to eight, which keeps any two refreshes within eight periods of each other.

A sequence first raises a hold request so that the controller closes every open row. It then waits for the controller to acknowledge that all banks are idle, and only then pulses the refresh command. After each command a recovery window runs. If debt is still owed and the controller is idle, or the debt is urgent, the next command follows right after the window and the banks do not have to be acknowledged again. Self-refresh entry is accepted only between sequences. Entry drives the clock-enable low, and the pacer leaves self refresh on request. On leaving, the debt is cleared, the interval restarts, and reads are blocked for a fixed lockout while the delay loop relocks.

Top module: `refresh_pacer`

## Requirements
- R1: While reset is held, owed_cnt is 0; pre_all_req, ref_issue, ref_urgent, sr_entry, in_self_ref and rd_block are 0; cke is 1.
- R2: Outside self refresh, owed_cnt grows by one every INTERVAL_CYC cycles and falls by one for each ref_issue pulse. While ref_issue is high, owed_cnt still shows the value from before that refresh.
- R3: owed_cnt never exceeds MAX_OWED and holds there when further intervals expire. ref_urgent is 1 exactly when owed_cnt equals MAX_OWED.
- R4: From the idle state, a refresh sequence starts when owed_cnt is above 0 and ctrl_idle is 1, or when ref_urgent is 1. In no other case is pre_all_req raised.
- R5: pre_all_req rises one cycle after the start decision and stays high through every pulse and recovery window of the sequence. ref_issue stays low for as long as banks_idle is low in that state.
- R6: Two ref_issue pulses are never closer than RECOVERY_CYC cycles. If at the end of recovery owed_cnt is above 0 and either ctrl_idle or ref_urgent is 1, the next pulse comes exactly RECOVERY_CYC cycles after the previous one, without a new banks_idle acknowledge.
- R7: sr_enter_req is accepted only in the idle state and has no effect while a refresh sequence is active. When it is accepted, sr_entry pulses for one cycle with cke low. After that, in_self_ref is 1 and cke stays 0.
- R8: In self refresh, ctrl_idle and banks_idle have no effect, no ref_issue pulse occurs, and owed_cnt does not change.
- R9: sr_exit_req in self refresh returns the block to idle on the next edge. From that edge, cke is 1, owed_cnt is 0 and rd_block is 1 for exactly LOCKOUT_CYC cycles. The interval restarts, so the first increment appears INTERVAL_CYC+1 cycles after the exit edge.
- R10: In the idle state, sr_enter_req takes priority over a pending refresh start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_idle | input | 1 | Controller has no pending traffic |
| banks_idle | input | 1 | Acknowledge that all banks are closed |
| sr_enter_req | input | 1 | Request to enter self refresh |
| sr_exit_req | input | 1 | Request to leave self refresh |
| pre_all_req | output | 1 | Hold request: close all rows and keep them closed |
| ref_issue | output | 1 | One-cycle refresh command strobe |
| ref_urgent | output | 1 | Owed count is at its ceiling |
| owed_cnt | output | $clog2(MAX_OWED+1) | Number of refreshes currently owed |
| cke | output | 1 | Clock-enable level for the memory |
| sr_entry | output | 1 | One-cycle self-refresh entry command strobe |
| in_self_ref | output | 1 | Memory is in self refresh |
| rd_block | output | 1 | Reads are not allowed (lockout after exit) |

## Verification
The assertions rely on three things about the controller. It keeps banks_idle meaningful only while the hold request is up, it asks to leave self refresh only after entry has completed, and RECOVERY_CYC is at least two. The stimulus raises banks_idle and ctrl_idle only at chosen points. It starts each burst right after an observed increment, so the debt values at each pulse are known in advance. It raises sr_exit_req only while in_self_ref is high. Toggling ctrl_idle and banks_idle during self refresh is the one place where inputs change freely, and there the design must ignore them.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_HOLD     = 3'd1,
    ST_FIRE     = 3'd2,
    ST_RECOVER  = 3'd3,
    ST_SR_ENTRY = 3'd4,
    ST_SR       = 3'd5
  } pacer_state_e;

endpackage

// File: rtl/pacer_interval_timer.sv
module pacer_interval_timer #(
  parameter int INTERVAL_CYC = 7800
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic tick
);
  localparam int TW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  a_r2_tick_is_pulse: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/pacer_owed_counter.sv
module pacer_owed_counter #(
  parameter int MAX_OWED = 8,
  parameter int OWED_W   = $clog2(MAX_OWED + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              inc,
  input  logic              dec,
  output logic [OWED_W-1:0] owed,
  output logic              urgent
);
  localparam logic [OWED_W-1:0] CEIL = OWED_W'(MAX_OWED);

  logic [OWED_W-1:0] owed_nx;

  always_comb begin
    owed_nx = owed;
    if (inc && !dec && owed != CEIL)
      owed_nx = owed + 1'b1;
    else if (dec && !inc && owed != '0)
      owed_nx = owed - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      owed   <= '0;
      urgent <= 1'b0;
    end else begin
      owed   <= owed_nx;
      urgent <= (owed_nx == CEIL);
    end
  end

  a_r3_never_above_ceiling: assert property (@(posedge clk) disable iff (rst)
    owed <= CEIL);

  a_r2_moves_by_one: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (owed == $past(owed) || owed == $past(owed) + 1'b1 ||
                owed + 1'b1 == $past(owed)));

endmodule

// File: rtl/pacer_lockout.sv
module pacer_lockout #(
  parameter int LOCKOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int LW = $clog2(LOCKOUT_CYC + 1);
  localparam logic [LW-1:0] LOAD = LW'(LOCKOUT_CYC);

  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      busy <= 1'b0;
    end else if (start) begin
      left <= LOAD;
      busy <= 1'b1;
    end else if (left != '0) begin
      left <= left - 1'b1;
      busy <= (left != LW'(1));
    end else begin
      busy <= 1'b0;
    end
  end

  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer
  import pacer_pkg::*;
#(
  parameter int INTERVAL_CYC = 7800,
  parameter int RECOVERY_CYC = 64,
  parameter int LOCKOUT_CYC  = 1000,
  parameter int MAX_OWED     = 8,
  localparam int OWED_W      = $clog2(MAX_OWED + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_idle,
  input  logic              banks_idle,
  input  logic              sr_enter_req,
  input  logic              sr_exit_req,
  output logic              pre_all_req,
  output logic              ref_issue,
  output logic              ref_urgent,
  output logic [OWED_W-1:0] owed_cnt,
  output logic              cke,
  output logic              sr_entry,
  output logic              in_self_ref,
  output logic              rd_block
);
  localparam int RW = (RECOVERY_CYC > 2) ? $clog2(RECOVERY_CYC) : 1;
  localparam logic [RW-1:0] REC_LOAD = RW'(RECOVERY_CYC - 2);
  localparam logic [RW-1:0] REC_GAP  = RW'(RECOVERY_CYC - 1);

  pacer_state_e st, st_nx;
  logic [RW-1:0] rec_left;
  logic          tick;
  logic          go;
  logic          sr_leave;

  pacer_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .hold (!cke),
    .tick (tick)
  );

  pacer_owed_counter #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_owed (
    .clk    (clk),
    .rst    (rst),
    .clear  (sr_leave),
    .inc    (tick),
    .dec    (ref_issue),
    .owed   (owed_cnt),
    .urgent (ref_urgent)
  );

  pacer_lockout #(.LOCKOUT_CYC(LOCKOUT_CYC)) u_lock (
    .clk   (clk),
    .rst   (rst),
    .start (sr_leave),
    .busy  (rd_block)
  );

  assign go       = (owed_cnt != '0) && (ctrl_idle || ref_urgent);
  assign sr_leave = (st == ST_SR) && sr_exit_req;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: begin
        if (sr_enter_req)
          st_nx = ST_SR_ENTRY;
        else if (go)
          st_nx = ST_HOLD;
      end
      ST_HOLD:     if (banks_idle) st_nx = ST_FIRE;
      ST_FIRE:     st_nx = ST_RECOVER;
      ST_RECOVER:  if (rec_left == '0) st_nx = go ? ST_FIRE : ST_IDLE;
      ST_SR_ENTRY: st_nx = ST_SR;
      ST_SR:       if (sr_exit_req) st_nx = ST_IDLE;
      default:     st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      rec_left    <= '0;
      pre_all_req <= 1'b0;
      ref_issue   <= 1'b0;
      cke         <= 1'b1;
      sr_entry    <= 1'b0;
      in_self_ref <= 1'b0;
    end else begin
      st          <= st_nx;
      pre_all_req <= (st_nx == ST_HOLD) || (st_nx == ST_FIRE) ||
                     (st_nx == ST_RECOVER);
      ref_issue   <= (st_nx == ST_FIRE);
      cke         <= !((st_nx == ST_SR_ENTRY) || (st_nx == ST_SR));
      sr_entry    <= (st_nx == ST_SR_ENTRY);
      in_self_ref <= (st_nx == ST_SR);
      if (st_nx == ST_FIRE)
        rec_left <= REC_LOAD;
      else if (st == ST_RECOVER && rec_left != '0)
        rec_left <= rec_left - 1'b1;
    end
  end

  // Cycles since the last refresh strobe, for the spacing check only.
  logic [RW-1:0] since_cnt;
  always_ff @(posedge clk) begin
    if (rst)
      since_cnt <= REC_GAP;
    else if (ref_issue)
      since_cnt <= '0;
    else if (since_cnt != REC_GAP)
      since_cnt <= since_cnt + 1'b1;
  end

  a_r5_wait_for_idle: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && !banks_idle) |=> !ref_issue);

  a_r6_min_spacing: assert property (@(posedge clk) disable iff (rst)
    ref_issue |-> since_cnt >= REC_GAP);

  a_r7_entry_between_sequences: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_entry) |-> !$past(pre_all_req));

  a_r8_owed_frozen: assert property (@(posedge clk) disable iff (rst)
    (in_self_ref && $past(in_self_ref)) |-> $stable(owed_cnt));

  a_r9_clean_exit: assert property (@(posedge clk) disable iff (rst)
    sr_leave |=> (owed_cnt == '0 && cke && !in_self_ref));

endmodule

// File: tb/sim_refresh_pacer.sv
`timescale 1ns/1ps
module sim_refresh_pacer;
  localparam int IV = 64;
  localparam int RC = 4;
  localparam int LK = 30;
  localparam int MX = 8;
  localparam int OW = $clog2(MX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_idle = 1'b0, banks_idle = 1'b0;
  logic sr_enter_req = 1'b0, sr_exit_req = 1'b0;
  logic pre_all_req, ref_issue, ref_urgent, cke, sr_entry, in_self_ref, rd_block;
  logic [OW-1:0] owed_cnt;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit finished = 1'b0;
  int exp_q[$];
  int pulse_t[$];

  refresh_pacer #(.INTERVAL_CYC(IV), .RECOVERY_CYC(RC), .LOCKOUT_CYC(LK),
                  .MAX_OWED(MX)) u0 (
    .clk(clk), .rst(rst), .ctrl_idle(ctrl_idle), .banks_idle(banks_idle),
    .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
    .pre_all_req(pre_all_req), .ref_issue(ref_issue), .ref_urgent(ref_urgent),
    .owed_cnt(owed_cnt), .cke(cke), .sr_entry(sr_entry),
    .in_self_ref(in_self_ref), .rd_block(rd_block)
  );

  always #4 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_owed(input int v);
    while (int'(owed_cnt) != v) @(negedge clk);
  endtask

  task automatic push_run(input int first, input int last);
    for (int v = first; v >= last; v--) exp_q.push_back(v);
  endtask

  // Monitor: each refresh strobe pops the expected debt value.
  always @(negedge clk) begin : monitor
    int gap;
    int e;
    if (!rst && ref_issue) begin
      if (pulse_t.size() > 0) begin
        gap = cyc - pulse_t[pulse_t.size()-1];
        chk("R6 spacing at least recovery", (gap >= RC) ? 1 : 0, 1);
      end
      pulse_t.push_back(cyc);
      chk("R5 hold high at strobe", int'(pre_all_req), 1);
      if (exp_q.size() == 0) begin
        chk("R4 unexpected refresh strobe", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk("R2 owed value at strobe", int'(owed_cnt), e);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : driver
    int t1, tT, c0, n;
    step(4);
    chk("R1 owed in reset", int'(owed_cnt), 0);
    chk("R1 hold in reset", int'(pre_all_req), 0);
    chk("R1 strobe in reset", int'(ref_issue), 0);
    chk("R1 urgent in reset", int'(ref_urgent), 0);
    chk("R1 cke in reset", int'(cke), 1);
    chk("R1 entry in reset", int'(sr_entry), 0);
    chk("R1 self in reset", int'(in_self_ref), 0);
    chk("R1 lockout in reset", int'(rd_block), 0);
    rst = 1'b0;
    banks_idle = 1'b1;

    // Debt grows while the controller is busy.
    wait_owed(1); t1 = cyc;
    wait_owed(2);
    chk("R2 interval length", cyc - t1, IV);
    chk("R4 no hold while busy and not urgent", int'(pre_all_req), 0);

    // Opportunistic burst.
    wait_owed(3);
    ctrl_idle = 1'b1;
    push_run(3, 1);
    step(20);
    chk("R4 opportunistic burst drained", int'(owed_cnt), 0);
    chk("R4 all expected strobes seen", exp_q.size(), 0);
    n = pulse_t.size();
    chk("R6 burst gap a", pulse_t[n-1] - pulse_t[n-2], RC);
    chk("R6 burst gap b", pulse_t[n-2] - pulse_t[n-3], RC);
    chk("R4 back to idle", int'(pre_all_req), 0);
    ctrl_idle = 1'b0;
    banks_idle = 1'b0;

    // Urgent refresh, waiting for the bank acknowledge.
    wait_owed(MX); tT = cyc;
    chk("R3 urgent at ceiling", int'(ref_urgent), 1);
    step(1);
    chk("R5 hold raised when urgent", int'(pre_all_req), 1);
    sr_enter_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1);
      chk("R7 entry ignored during sequence (cke)", int'(cke), 1);
      chk("R7 entry ignored during sequence (strobe)", int'(sr_entry), 0);
    end
    sr_enter_req = 1'b0;
    while (cyc != tT + 70) step(1);
    chk("R3 owed held at ceiling", int'(owed_cnt), MX);
    chk("R3 urgent still high", int'(ref_urgent), 1);
    chk("R5 no strobe before acknowledge", int'(ref_issue), 0);
    push_run(MX, 1);
    banks_idle = 1'b1;
    ctrl_idle = 1'b1;
    step(40);
    chk("R6 urgent burst drained", int'(owed_cnt), 0);
    chk("R6 urgent burst strobes", exp_q.size(), 0);
    n = pulse_t.size();
    for (int k = 1; k < MX; k++)
      chk("R6 back-to-back spacing", pulse_t[n-k] - pulse_t[n-k-1], RC);
    ctrl_idle = 1'b0;

    // Self refresh with a pending refresh: entry wins.
    wait_owed(1);
    ctrl_idle = 1'b1;
    sr_enter_req = 1'b1;
    step(1);
    chk("R10 entry strobe over pending refresh", int'(sr_entry), 1);
    chk("R10 no hold on entry", int'(pre_all_req), 0);
    chk("R7 cke low on entry", int'(cke), 0);
    sr_enter_req = 1'b0;
    step(1);
    chk("R7 entry strobe one cycle", int'(sr_entry), 0);
    chk("R7 in self refresh", int'(in_self_ref), 1);
    chk("R7 cke stays low", int'(cke), 0);
    for (int i = 0; i < 150; i++) begin
      banks_idle = i[0];
      ctrl_idle  = i[1];
      step(1);
    end
    chk("R8 owed frozen in self refresh", int'(owed_cnt), 1);
    chk("R8 cke still low", int'(cke), 0);
    chk("R8 no hold in self refresh", int'(pre_all_req), 0);

    // Exit and lockout.
    ctrl_idle = 1'b0;
    banks_idle = 1'b1;
    sr_exit_req = 1'b1;
    step(1);
    sr_exit_req = 1'b0;
    c0 = cyc;
    chk("R9 cke high after exit", int'(cke), 1);
    chk("R9 left self refresh", int'(in_self_ref), 0);
    chk("R9 owed cleared", int'(owed_cnt), 0);
    chk("R9 lockout raised", int'(rd_block), 1);
    n = 1;
    step(1);
    while (rd_block) begin
      n++;
      step(1);
    end
    chk("R9 lockout length", n, LK);
    wait_owed(1);
    chk("R9 interval restarts at exit", cyc - c0, IV + 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule